// File: doc/BRIEF.md
# Packet header address swapper

This block rewrites the addressing of a packet header that already sits in memory. A byte address arrives on a valid/ready input stream. The block then reads the header words with one AXI4 read burst and holds every word in an internal buffer. It writes the words back to the same place with one AXI4 write burst. Before the write, the layer-2 hardware addresses trade places, and so do the layer-3 IPv4 addresses. All other header bytes go back exactly as they were read.

The header span is 34 bytes. The block moves NW = ceil(272 / DATA_WIDTH) words: 9 words at 32 bits, 5 at 64 and 3 at 128. Byte k of the span lives in byte lane k mod (DATA_WIDTH/8) of word k / (DATA_WIDTH/8). Lane 0 is bits 7:0. Only one packet is in progress at a time. The block takes a new address only after the write response of the current packet has been received. Every AXI channel may be stalled by the memory side for any length of time.

Top module: `hdr_addr_swap`

## Requirements
- R1: After reset, in_ready is 1 and m_arvalid, m_awvalid, m_wvalid and m_bready are 0.
- R2: Each accepted address causes exactly one read request with m_araddr equal to that address, m_arlen = NW-1, m_arsize = log2(DATA_WIDTH/8) and m_arburst = 2'b01 (incrementing).
- R3: Neither m_awvalid nor m_wvalid is raised before all NW read beats of the current packet have been accepted.
- R4: The write burst uses m_awaddr equal to the packet address, m_awlen = NW-1, m_awsize = log2(DATA_WIDTH/8) and m_awburst = 2'b01. Every beat has m_wstrb all ones, and m_wlast is 1 on beat NW-1 only.
- R5: Header bytes 0..5 and bytes 6..11 are exchanged, and byte order within each 6-byte field is kept.
- R6: Header bytes 26..29 and bytes 30..33 are exchanged, and byte order within each 4-byte field is kept.
- R7: Header bytes 12..25 and bytes 34..NW*DATA_WIDTH/8-1 are written back unchanged. Memory outside the written span is not touched.
- R8: in_ready is 0 from the address handshake until the write response handshake. The next address is accepted only after that handshake.
- R9: With a memory that never stalls, the write response handshake happens within 100 clock cycles of the address handshake.
- R10: A valid on AR, AW or W is held, with its address or data stable, until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Header address offered |
| in_ready | output | 1 | Block idle, address taken |
| in_addr | input | ADDR_WIDTH | Byte address of the header |
| m_arvalid | output | 1 | Read request valid |
| m_arready | input | 1 | Read request accepted |
| m_araddr | output | ADDR_WIDTH | Read burst start address |
| m_arlen | output | 8 | Read beats minus one |
| m_arsize | output | 3 | Read beat size code |
| m_arburst | output | 2 | Read burst type |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data accepted |
| m_rdata | input | DATA_WIDTH | Read data word |
| m_awvalid | output | 1 | Write request valid |
| m_awready | input | 1 | Write request accepted |
| m_awaddr | output | ADDR_WIDTH | Write burst start address |
| m_awlen | output | 8 | Write beats minus one |
| m_awsize | output | 3 | Write beat size code |
| m_awburst | output | 2 | Write burst type |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data accepted |
| m_wdata | output | DATA_WIDTH | Write data word |
| m_wstrb | output | DATA_WIDTH/8 | Write byte strobes |
| m_wlast | output | 1 | Final write beat |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response accepted |

## Verification
The first inputs are random headers with a memory that never stalls, which checks the swap itself and the latency bound. A header whose bytes all hold one value must come back unchanged. A header whose bytes count upward shows whether a field was moved with its byte order kept or whether bytes were shifted into the wrong lane, as opposed to cases where the result simply matches. The same address is sent twice back to back. The original header must then come back, and the second address must wait for the first write response. Runs of random addresses with moderate and heavy stalls on every channel show whether held valids, stable data and the read-before-write order survive back-pressure.

// File: rtl/hdr_swap_pkg.sv
`timescale 1ns/1ps
package hdr_swap_pkg;
    localparam int HDR_BYTES = 34;
    localparam int L2_A_OFS  = 0;
    localparam int L2_B_OFS  = 6;
    localparam int L2_LEN    = 6;
    localparam int L3_A_OFS  = 26;
    localparam int L3_B_OFS  = 30;
    localparam int L3_LEN    = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RADDR,
        ST_RDATA,
        ST_WRITE,
        ST_RESP
    } swap_state_e;

    // Byte of the read image that lands on output byte b
    function automatic int src_byte(input int b);
        if (b < L2_A_OFS + L2_LEN)                        return b + (L2_B_OFS - L2_A_OFS);
        if (b >= L2_B_OFS && b < L2_B_OFS + L2_LEN)       return b - (L2_B_OFS - L2_A_OFS);
        if (b >= L3_A_OFS && b < L3_A_OFS + L3_LEN)       return b + (L3_B_OFS - L3_A_OFS);
        if (b >= L3_B_OFS && b < L3_B_OFS + L3_LEN)       return b - (L3_B_OFS - L3_A_OFS);
        return b;
    endfunction
endpackage

// File: rtl/hdr_swap_net.sv
`timescale 1ns/1ps
module hdr_swap_net #(
    parameter int NBYTES = 40
) (
    input  logic [NBYTES*8-1:0] raw,
    output logic [NBYTES*8-1:0] swp
);
    // Fixed byte permutation: pure wiring, no logic levels
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        localparam int SRC = hdr_swap_pkg::src_byte(b);
        assign swp[b*8 +: 8] = raw[SRC*8 +: 8];
    end
endmodule

// File: rtl/hdr_swap_store.sv
`timescale 1ns/1ps
module hdr_swap_store #(
    parameter int DW = 64,
    parameter int NW = 5,
    parameter int CW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CW-1:0]    idx,
    input  logic [DW-1:0]    wdat,
    output logic [NW*DW-1:0] words
);
    logic [NW*DW-1:0] words_d, words_q;

    always_comb begin
        words_d = words_q;
        for (int i = 0; i < NW; i++) begin
            if (we && idx == CW'(i)) begin
                words_d[i*DW +: DW] = wdat;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) words_q <= '0;
        else        words_q <= words_d;
    end

    assign words = words_q;
endmodule

// File: rtl/hdr_swap_fsm.sv
`timescale 1ns/1ps
module hdr_swap_fsm
    import hdr_swap_pkg::*;
#(
    parameter int AW = 32,
    parameter int NW = 5,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [AW-1:0] in_addr,
    output logic          ar_valid,
    input  logic          ar_ready,
    input  logic          r_valid,
    output logic          r_ready,
    output logic          aw_valid,
    input  logic          aw_ready,
    output logic          w_valid,
    input  logic          w_ready,
    output logic          w_last,
    input  logic          b_valid,
    output logic          b_ready,
    output logic [AW-1:0] base_addr,
    output logic          rd_we,
    output logic [CW-1:0] rd_idx,
    output logic [CW-1:0] wr_idx
);
    localparam logic [CW-1:0] LAST = CW'(NW - 1);
    localparam logic [CW-1:0] FULL = CW'(NW);

    typedef struct packed {
        swap_state_e   st;
        logic [AW-1:0] addr;
        logic [CW-1:0] rcnt;
        logic [CW-1:0] wcnt;
        logic          aw_done;
    } ctl_t;

    ctl_t c_d, c_q;
    logic aw_fin, w_fin;

    always_comb begin
        c_d      = c_q;
        in_ready = 1'b0;
        ar_valid = 1'b0;
        r_ready  = 1'b0;
        aw_valid = 1'b0;
        w_valid  = 1'b0;
        w_last   = 1'b0;
        b_ready  = 1'b0;
        rd_we    = 1'b0;
        aw_fin   = 1'b0;
        w_fin    = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    c_d.addr = in_addr;
                    c_d.st   = ST_RADDR;
                end
            end
            ST_RADDR: begin
                ar_valid = 1'b1;
                if (ar_ready) begin
                    c_d.rcnt = '0;
                    c_d.st   = ST_RDATA;
                end
            end
            ST_RDATA: begin
                r_ready = 1'b1;
                if (r_valid) begin
                    rd_we    = 1'b1;
                    c_d.rcnt = c_q.rcnt + 1'b1;
                    if (c_q.rcnt == LAST) begin
                        c_d.wcnt    = '0;
                        c_d.aw_done = 1'b0;
                        c_d.st      = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                // address and data channels run side by side
                aw_valid = !c_q.aw_done;
                w_valid  = (c_q.wcnt != FULL);
                w_last   = (c_q.wcnt == LAST);
                aw_fin   = c_q.aw_done || aw_ready;
                w_fin    = (c_q.wcnt == FULL) || (w_ready && w_last);
                if (aw_valid && aw_ready) c_d.aw_done = 1'b1;
                if (w_valid && w_ready)   c_d.wcnt    = c_q.wcnt + 1'b1;
                if (aw_fin && w_fin)      c_d.st      = ST_RESP;
            end
            ST_RESP: begin
                b_ready = 1'b1;
                if (b_valid) c_d.st = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.st      <= ST_IDLE;
            c_q.addr    <= '0;
            c_q.rcnt    <= '0;
            c_q.wcnt    <= '0;
            c_q.aw_done <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign base_addr = c_q.addr;
    assign rd_idx    = c_q.rcnt;
    assign wr_idx    = c_q.wcnt;
endmodule

// File: rtl/hdr_addr_swap.sv
`timescale 1ns/1ps
module hdr_addr_swap #(
    parameter int DATA_WIDTH = 64,
    parameter int ADDR_WIDTH = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [ADDR_WIDTH-1:0]   in_addr,
    output logic                    m_arvalid,
    input  logic                    m_arready,
    output logic [ADDR_WIDTH-1:0]   m_araddr,
    output logic [7:0]              m_arlen,
    output logic [2:0]              m_arsize,
    output logic [1:0]              m_arburst,
    input  logic                    m_rvalid,
    output logic                    m_rready,
    input  logic [DATA_WIDTH-1:0]   m_rdata,
    output logic                    m_awvalid,
    input  logic                    m_awready,
    output logic [ADDR_WIDTH-1:0]   m_awaddr,
    output logic [7:0]              m_awlen,
    output logic [2:0]              m_awsize,
    output logic [1:0]              m_awburst,
    output logic                    m_wvalid,
    input  logic                    m_wready,
    output logic [DATA_WIDTH-1:0]   m_wdata,
    output logic [DATA_WIDTH/8-1:0] m_wstrb,
    output logic                    m_wlast,
    input  logic                    m_bvalid,
    output logic                    m_bready
);
    localparam int DB = DATA_WIDTH / 8;
    localparam int NW = (hdr_swap_pkg::HDR_BYTES * 8 + DATA_WIDTH - 1) / DATA_WIDTH;
    localparam int CW = $clog2(NW + 1);
    localparam int SZ = $clog2(DB);

    logic [ADDR_WIDTH-1:0]    base_addr;
    logic                     rd_we;
    logic [CW-1:0]            rd_idx, wr_idx;
    logic [NW*DATA_WIDTH-1:0] raw_words, swp_words;

    hdr_swap_fsm #(.AW(ADDR_WIDTH), .NW(NW), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
        .ar_valid(m_arvalid), .ar_ready(m_arready),
        .r_valid(m_rvalid), .r_ready(m_rready),
        .aw_valid(m_awvalid), .aw_ready(m_awready),
        .w_valid(m_wvalid), .w_ready(m_wready), .w_last(m_wlast),
        .b_valid(m_bvalid), .b_ready(m_bready),
        .base_addr(base_addr), .rd_we(rd_we), .rd_idx(rd_idx), .wr_idx(wr_idx)
    );

    hdr_swap_store #(.DW(DATA_WIDTH), .NW(NW), .CW(CW)) u_store (
        .clk(clk), .rst_n(rst_n), .we(rd_we), .idx(rd_idx),
        .wdat(m_rdata), .words(raw_words)
    );

    hdr_swap_net #(.NBYTES(NW * DB)) u_net (
        .raw(raw_words), .swp(swp_words)
    );

    always_comb begin
        m_wdata = '0;
        for (int i = 0; i < NW; i++) begin
            if (wr_idx == CW'(i)) m_wdata = swp_words[i*DATA_WIDTH +: DATA_WIDTH];
        end
    end

    assign m_araddr  = base_addr;
    assign m_arlen   = 8'(NW - 1);
    assign m_arsize  = 3'(SZ);
    assign m_arburst = 2'b01;
    assign m_awaddr  = base_addr;
    assign m_awlen   = 8'(NW - 1);
    assign m_awsize  = 3'(SZ);
    assign m_awburst = 2'b01;
    assign m_wstrb   = '1;
endmodule

// File: rtl/hdr_addr_swap_chk.sv
`timescale 1ns/1ps
module hdr_addr_swap_chk #(
    parameter int DATA_WIDTH = 64,
    parameter int ADDR_WIDTH = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic                  m_arvalid,
    input logic                  m_arready,
    input logic [ADDR_WIDTH-1:0] m_araddr,
    input logic                  m_rvalid,
    input logic                  m_rready,
    input logic                  m_awvalid,
    input logic                  m_awready,
    input logic [ADDR_WIDTH-1:0] m_awaddr,
    input logic                  m_wvalid,
    input logic                  m_wready,
    input logic [DATA_WIDTH-1:0] m_wdata,
    input logic                  m_wlast,
    input logic                  m_bvalid,
    input logic                  m_bready
);
    localparam int NW = (hdr_swap_pkg::HDR_BYTES * 8 + DATA_WIDTH - 1) / DATA_WIDTH;

    logic [7:0] rb_q, wb_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_q <= 8'd0;
            wb_q <= 8'd0;
        end else if (in_valid && in_ready) begin
            rb_q <= 8'd0;
            wb_q <= 8'd0;
        end else begin
            if (m_rvalid && m_rready) rb_q <= rb_q + 8'd1;
            if (m_wvalid && m_wready) wb_q <= wb_q + 8'd1;
        end
    end

    assert_no_early_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid || m_wvalid) |-> rb_q == 8'(NW));

    assert_last_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && m_wlast) |-> wb_q == 8'(NW - 1));

    assert_no_extra_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid |-> wb_q < 8'(NW));

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    assert_idle_after_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_bvalid && m_bready) |=> in_ready);

    assert_ar_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid && !m_arready) |=> m_arvalid && $stable(m_araddr));

    assert_aw_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> m_awvalid && $stable(m_awaddr));

    assert_w_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && !m_wready) |=> m_wvalid && $stable(m_wdata) && $stable(m_wlast));
endmodule

bind hdr_addr_swap hdr_addr_swap_chk #(.DATA_WIDTH(DATA_WIDTH), .ADDR_WIDTH(ADDR_WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
    .m_rvalid(m_rvalid), .m_rready(m_rready),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wlast(m_wlast),
    .m_bvalid(m_bvalid), .m_bready(m_bready)
);

// File: tb/test_hdr_addr_swap.sv
`timescale 1ns/1ps
module test_hdr_addr_swap;
    localparam int DW  = 64;
    localparam int AW  = 32;
    localparam int DB  = DW / 8;
    localparam int NW  = (34 * 8 + DW - 1) / DW;
    localparam int NB  = NW * DB;
    localparam int MEM = 1024;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid, in_ready;
    logic [AW-1:0] in_addr;
    logic m_arvalid, m_arready, m_rvalid, m_rready;
    logic [AW-1:0] m_araddr, m_awaddr;
    logic [7:0] m_arlen, m_awlen;
    logic [2:0] m_arsize, m_awsize;
    logic [1:0] m_arburst, m_awburst;
    logic [DW-1:0] m_rdata, m_wdata;
    logic m_awvalid, m_awready, m_wvalid, m_wready, m_wlast, m_bvalid, m_bready;
    logic [DB-1:0] m_wstrb;

    always #2.5 clk = ~clk;

    hdr_addr_swap #(.DATA_WIDTH(DW), .ADDR_WIDTH(AW)) i_hdr_addr_swap (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
        .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
        .m_arlen(m_arlen), .m_arsize(m_arsize), .m_arburst(m_arburst),
        .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
        .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata),
        .m_wstrb(m_wstrb), .m_wlast(m_wlast),
        .m_bvalid(m_bvalid), .m_bready(m_bready)
    );

    logic [7:0] mem  [MEM];
    logic [7:0] gold [MEM];
    int n_checks = 0, n_err = 0;
    int stall = 0, cyc = 0, done_cnt = 0, sent_cnt = 0;
    bit fin = 0;
    int q_addr[$];
    int q_t0[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int ref_src(input int b);
        if (b < 6)             return b + 6;
        if (b < 12)            return b - 6;
        if (b >= 26 && b < 30) return b + 4;
        if (b >= 30 && b < 34) return b - 4;
        return b;
    endfunction

    function automatic bit roll();
        return $urandom_range(0, 99) >= stall;
    endfunction

    // Monitor side: apply the expected swap to the model, compare to memory
    task automatic score(input int a);
        logic [7:0] tmp [NB];
        string req;
        for (int b = 0; b < NB; b++) tmp[b] = gold[a + b];
        for (int b = 0; b < NB; b++) gold[a + b] = tmp[ref_src(b)];
        for (int b = 0; b < NB; b++) begin
            req = (b < 12) ? "R5" : ((b >= 26 && b < 34) ? "R6" : "R7");
            chk(mem[a + b] == gold[a + b], req, $sformatf("byte %0d at %0d", b, a),
                longint'(mem[a + b]), longint'(gold[a + b]));
        end
    endtask

    // Memory slave with random stalls
    bit ar_f, r_f, aw_f, w_f, b_f, rv, bv, rd_act, aw_got;
    bit ar_pend, aw_pend, w_pend;
    logic [AW-1:0] ar_sav, aw_sav;
    logic [DW-1:0] w_sav;
    bit wl_sav;
    int rbeat, wbeat, rd_base, wr_base;
    logic [DW-1:0] wbuf [NW];

    initial begin
        {ar_f, r_f, aw_f, w_f, b_f, rv, bv, rd_act, aw_got} = '0;
        {ar_pend, aw_pend, w_pend} = '0;
        rbeat = NW; wbeat = 0; rd_base = 0; wr_base = 0;
        m_arready = 0; m_rvalid = 0; m_rdata = '0; m_awready = 0; m_wready = 0; m_bvalid = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (ar_pend) chk(m_arvalid && m_araddr == ar_sav, "R10", "AR held", longint'(m_araddr), longint'(ar_sav));
            if (aw_pend) chk(m_awvalid && m_awaddr == aw_sav, "R10", "AW held", longint'(m_awaddr), longint'(aw_sav));
            if (w_pend)  chk(m_wvalid && m_wdata == w_sav && m_wlast == wl_sav, "R10", "W held",
                             longint'(m_wdata[31:0]), longint'(w_sav[31:0]));
            if (ar_f) begin rd_act = 1; rbeat = 0; end
            if (r_f) begin rbeat++; rv = 0; if (rbeat == NW) rd_act = 0; end
            if (aw_f) aw_got = 1;
            if (w_f) wbeat++;
            if (b_f) begin bv = 0; aw_got = 0; wbeat = 0; end
            if (!bv && aw_got && wbeat == NW && roll()) begin
                for (int i = 0; i < NW; i++)
                    for (int k = 0; k < DB; k++)
                        mem[(wr_base + i * DB + k) % MEM] = wbuf[i][k*8 +: 8];
                bv = 1;
            end
            if (rd_act && !rv && roll()) rv = 1;
            for (int k = 0; k < DB; k++) m_rdata[k*8 +: 8] = mem[(rd_base + rbeat * DB + k) % MEM];
            m_rvalid  = rv;
            m_bvalid  = bv;
            m_arready = roll();
            m_awready = roll();
            m_wready  = roll();
            // handshakes that the coming edge will take
            ar_f = m_arvalid && m_arready;
            r_f  = m_rvalid && m_rready;
            aw_f = m_awvalid && m_awready;
            w_f  = m_wvalid && m_wready;
            b_f  = m_bvalid && m_bready;
            ar_pend = m_arvalid && !m_arready; ar_sav = m_araddr;
            aw_pend = m_awvalid && !m_awready; aw_sav = m_awaddr;
            w_pend  = m_wvalid && !m_wready;   w_sav = m_wdata; wl_sav = m_wlast;
            if (ar_f) begin
                chk(q_addr.size() > 0 && m_araddr == AW'(q_addr[0]), "R2", "araddr", longint'(m_araddr),
                    longint'(q_addr.size() > 0 ? q_addr[0] : -1));
                chk(m_arlen == 8'(NW - 1) && m_arsize == 3'($clog2(DB)) && m_arburst == 2'b01, "R2",
                    "arlen/size/burst", longint'({m_arlen, m_arsize, m_arburst}),
                    longint'({8'(NW - 1), 3'($clog2(DB)), 2'b01}));
                rd_base = int'(m_araddr);
            end
            if (aw_f) begin
                chk(rbeat == NW, "R3", "AW before reads done", longint'(rbeat), longint'(NW));
                chk(q_addr.size() > 0 && m_awaddr == AW'(q_addr[0]), "R4", "awaddr", longint'(m_awaddr),
                    longint'(q_addr.size() > 0 ? q_addr[0] : -1));
                chk(m_awlen == 8'(NW - 1) && m_awsize == 3'($clog2(DB)) && m_awburst == 2'b01, "R4",
                    "awlen/size/burst", longint'({m_awlen, m_awsize, m_awburst}),
                    longint'({8'(NW - 1), 3'($clog2(DB)), 2'b01}));
                wr_base = int'(m_awaddr);
            end
            if (w_f) begin
                chk(rbeat == NW, "R3", "W before reads done", longint'(rbeat), longint'(NW));
                chk(m_wstrb == '1, "R4", "wstrb", longint'(m_wstrb), longint'({DB{1'b1}}));
                chk(m_wlast == (wbeat == NW - 1), "R4", $sformatf("wlast beat %0d", wbeat),
                    longint'(m_wlast), longint'(wbeat == NW - 1));
                if (wbeat < NW) wbuf[wbeat] = m_wdata;
            end
            if (b_f && q_addr.size() > 0) begin
                if (stall == 0)
                    chk(cyc - q_t0[0] <= 100, "R9", "latency", longint'(cyc - q_t0[0]), 100);
                score(q_addr[0]);
                void'(q_addr.pop_front());
                void'(q_t0.pop_front());
                done_cnt++;
            end
        end
    end

    // Driver: offer an address and record it for the monitor
    task automatic send(input int a);
        q_addr.push_back(a);
        in_addr  = AW'(a);
        in_valid = 1'b1;
        while (in_ready !== 1'b1) @(negedge clk);
        chk(done_cnt == sent_cnt, "R8", "accepted before previous response", longint'(done_cnt), longint'(sent_cnt));
        sent_cnt++;
        q_t0.push_back(cyc);
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R8", "in_ready while busy", longint'(in_ready), 0);
    endtask

    task automatic wait_idle();
        while (done_cnt != sent_cnt) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic preload(input int a, input int kind);
        for (int b = 0; b < NB; b++) begin
            mem[a + b]  = (kind == 0) ? 8'hA5 : 8'(b + 1);
            gold[a + b] = mem[a + b];
        end
    endtask

    function automatic int rnd_addr();
        return $urandom_range(0, (MEM - NB) / DB) * DB;
    endfunction

    initial begin
        int diffs;
        for (int i = 0; i < MEM; i++) begin
            mem[i]  = 8'($urandom);
            gold[i] = mem[i];
        end
        rst_n = 1'b0; in_valid = 1'b0; in_addr = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1", "in_ready", longint'(in_ready), 1);
        chk({m_arvalid, m_awvalid, m_wvalid, m_bready} == 4'b0, "R1", "valids idle",
            longint'({m_arvalid, m_awvalid, m_wvalid, m_bready}), 0);

        stall = 0;
        send(0);   wait_idle();
        send(128); wait_idle();
        preload(256, 0); send(256); wait_idle();
        preload(512, 1); send(512); wait_idle();

        stall = 50;
        send(64); send(64); wait_idle();
        for (int n = 0; n < 8; n++) send(rnd_addr());
        wait_idle();

        stall = 85;
        preload(320, 1); send(320);
        for (int n = 0; n < 4; n++) send(rnd_addr());
        wait_idle();

        diffs = 0;
        for (int i = 0; i < MEM; i++) if (mem[i] != gold[i]) diffs++;
        chk(diffs == 0, "R7", "whole memory image", longint'(diffs), 0);

        fin = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d responses", done_cnt, sent_cnt);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule